// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit path from a ring of descriptors kept in memory. Software loads the ring base address, prepares descriptors, and then rings a doorbell. The engine reads the descriptor at its current ring index. If hardware owns that descriptor, the engine fetches the referenced buffer through a simple request/acknowledge memory port and sends it out one byte per handshake on a byte stream. It then writes the status word back with ownership returned to software and moves to the next slot. It keeps walking until it meets a descriptor it does not own. A descriptor flagged as last in the ring sends the walk back to slot zero.

Each descriptor takes 16 bytes at base + 16 × index. Word +0 holds status and command, word +4 a tag the engine never reads, word +8 the buffer address, and word +12 the upper address half, which this engine also does not read. The status word carries the ownership flag (bit 31), the end-of-ring flag (bit 30), the frame-start flag (bit 29), the frame-end flag (bit 28) and a 13-bit byte count (bits 12:0). Bits 27:13 are carried through unchanged.

The controller has six states. IDLE waits for a doorbell. FETCH_STAT reads the status word and goes to FETCH_BUF when the descriptor is owned. If it is not owned, it goes back to IDLE, or rescans in FETCH_STAT when a doorbell is pending. FETCH_BUF reads the buffer address and goes to WRITE_BACK for a zero count, otherwise to FETCH_WORD. FETCH_WORD reads one buffer word and goes to SEND. SEND hands out bytes. It returns to FETCH_WORD after every fourth byte and goes to WRITE_BACK after the last one. WRITE_BACK stores the status word, advances the index and returns to FETCH_STAT.

Top module: `tx_ring_fetch`

## Requirements
- R1: After reset there is no memory request, no stream byte, both status flags read 0, and the ring index is 0.
- R2: A poll write with poll_data bit 6 set starts a status read at base + 16 × index. A poll write with bit 6 clear starts nothing.
- R3: A fetched status word with bit 31 clear makes the engine stop without any write and leaves the index unchanged, so the next doorbell reads the same slot.
- R4: For an owned descriptor the engine streams exactly bits 12:0 bytes. The buffer is read from the word address at descriptor offset +8, and byte k comes from the word at buffer + 4·⌊k/4⌋, bits 8·(k mod 4)+7 down to 8·(k mod 4).
- R5: tx_first is high only on byte 0, and only when status bit 29 is set. tx_last is high only on the final byte, and only when status bit 28 is set.
- R6: After the bytes have gone out, the status word is written back to the same address with bit 31 cleared and all other bits unchanged.
- R7: After a write-back the index moves to the next slot. When status bit 30 was set it returns to 0 instead. The walk goes on until it meets a descriptor that is not owned.
- R8: A byte count of zero streams nothing. The descriptor is still written back, and int_status bit 3 is set.
- R9: A write-back with a nonzero count sets int_status bit 2. Each flag stays set until a cycle with the matching int_clr bit high clears it.
- R10: A doorbell that arrives while the engine is busy is held. The next descriptor found not owned is then read once more before the engine goes idle.
- R11: A memory request keeps its address, direction and write data until it is acknowledged. A stream byte keeps its data and flags until tx_ready is high.
- R12: Loading a base address sets the ring index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr | input | 1 | Load strobe for the ring base |
| base_addr | input | AW | Ring base byte address |
| poll_wr | input | 1 | Poll register write strobe |
| poll_data | input | 8 | Poll register data; bit 6 is the doorbell |
| int_clr | input | 8 | Write-one-to-clear mask for int_status |
| int_status | output | 8 | Bit 2 transmit done, bit 3 transmit error |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
A doorbell is registered at the first rising edge, and the status read is requested in the next cycle. Each later request is raised in the cycle after the previous acknowledge. A stream byte changes in the cycle after it is accepted, and a status flag becomes visible in the cycle after the write-back acknowledge. The bench memory answers with a random latency and the sink stalls at random, so exact cycle numbers are not fixed. The checks therefore compare order and content, not timing. Reads, write-backs and accepted bytes are logged at the edge where they complete. Each scenario is judged only after 30 falling-edge samples in a row with no request and no valid byte, and the flags are read at that point.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int LEN_W   = 13;
    localparam int OWN_B   = 31;
    localparam int EOR_B   = 30;
    localparam int FS_B    = 29;
    localparam int LS_B    = 28;
    localparam int POLL_B  = 6;
    localparam int OK_B    = 2;
    localparam int ERR_B   = 3;
    localparam int DESC_SH = 4;   // 16-byte descriptors
    localparam int BUF_OFS = 8;   // buffer address word offset

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_STAT,
        ST_FETCH_BUF,
        ST_FETCH_WORD,
        ST_SEND,
        ST_WRITE_BACK
    } txr_state_e;
endpackage

// File: rtl/txr_addr_gen.sv
module txr_addr_gen
    import txr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  txr_state_e       state,
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    input  logic [AW-1:0]    buf_base,
    input  logic [LEN_W-1:0] cnt,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] desc_a;
    logic [AW-1:0] word_ofs;

    always_comb begin
        desc_a   = base + AW'({idx, {DESC_SH{1'b0}}});
        word_ofs = AW'({cnt[LEN_W-1:2], 2'b00});
        unique case (state)
            ST_FETCH_STAT, ST_WRITE_BACK: addr = desc_a;
            ST_FETCH_BUF:                 addr = desc_a + AW'(BUF_OFS);
            ST_FETCH_WORD:                addr = buf_base + word_ofs;
            default:                      addr = '0;
        endcase
    end
endmodule

// File: rtl/txr_byte_sel.sv
module txr_byte_sel #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]            word,
    input  logic [$clog2(DW/8)-1:0]  sel,
    output logic [7:0]               byte_o
);
    localparam int NB = DW / 8;

    logic [7:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[sel];
endmodule

// File: rtl/txr_int_flags.sv
module txr_int_flags
    import txr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ok,
    input  logic       set_err,
    input  logic [7:0] clr,
    output logic [7:0] flags
);
    logic [7:0] set_v;

    always_comb begin
        set_v        = '0;
        set_v[OK_B]  = set_ok;
        set_v[ERR_B] = set_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch
    import txr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_addr,
    input  logic          poll_wr,
    input  logic [7:0]    poll_data,
    input  logic [7:0]    int_clr,
    output logic [7:0]    int_status,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_first,
    output logic          tx_last,
    input  logic          tx_ready
);
    txr_state_e       st_q, st_d;
    logic [AW-1:0]    base_q, buf_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      stat_q, word_q;
    logic [LEN_W-1:0] cnt_q, len;
    logic             pend_q, doorbell, len_zero, last_byte;
    logic             set_ok, set_err;
    logic             unused_poll;

    assign doorbell    = poll_wr & poll_data[POLL_B];
    assign unused_poll = ^{poll_data[7], poll_data[5:0]};
    assign len         = stat_q[LEN_W-1:0];
    assign len_zero    = (len == '0);
    assign last_byte   = (cnt_q == len - LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:
                if (doorbell) st_d = ST_FETCH_STAT;
            ST_FETCH_STAT:
                if (mem_ack) begin
                    if (mem_rdata[OWN_B])         st_d = ST_FETCH_BUF;
                    else if (pend_q || doorbell)  st_d = ST_FETCH_STAT;
                    else                          st_d = ST_IDLE;
                end
            ST_FETCH_BUF:
                if (mem_ack) st_d = len_zero ? ST_WRITE_BACK : ST_FETCH_WORD;
            ST_FETCH_WORD:
                if (mem_ack) st_d = ST_SEND;
            ST_SEND:
                if (tx_ready) begin
                    if (last_byte)         st_d = ST_WRITE_BACK;
                    else if (&cnt_q[1:0])  st_d = ST_FETCH_WORD;
                end
            ST_WRITE_BACK:
                if (mem_ack) st_d = ST_FETCH_STAT;
            default:
                st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            buf_q  <= '0;
            idx_q  <= '0;
            stat_q <= '0;
            word_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (base_wr) begin
                base_q <= base_addr;
                idx_q  <= '0;
            end else if (st_q == ST_WRITE_BACK && mem_ack) begin
                idx_q  <= stat_q[EOR_B] ? '0 : idx_q + IDX_W'(1);
            end
            if (st_q == ST_FETCH_STAT && mem_ack && !mem_rdata[OWN_B])
                pend_q <= 1'b0;
            else if (doorbell && st_q != ST_IDLE)
                pend_q <= 1'b1;
            if (st_q == ST_FETCH_STAT && mem_ack) stat_q <= mem_rdata;
            if (st_q == ST_FETCH_BUF && mem_ack) begin
                buf_q <= AW'(mem_rdata);
                cnt_q <= '0;
            end
            if (st_q == ST_FETCH_WORD && mem_ack) word_q <= mem_rdata;
            if (st_q == ST_SEND && tx_ready) cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        mem_req   = (st_q == ST_FETCH_STAT) || (st_q == ST_FETCH_BUF) ||
                    (st_q == ST_FETCH_WORD) || (st_q == ST_WRITE_BACK);
        mem_we    = (st_q == ST_WRITE_BACK);
        mem_wdata = {1'b0, stat_q[OWN_B-1:0]};
        tx_valid  = (st_q == ST_SEND);
        tx_first  = tx_valid && (cnt_q == '0) && stat_q[FS_B];
        tx_last   = tx_valid && last_byte && stat_q[LS_B];
        set_ok    = (st_q == ST_WRITE_BACK) && mem_ack && !len_zero;
        set_err   = (st_q == ST_WRITE_BACK) && mem_ack && len_zero;
    end

    txr_addr_gen #(.AW(AW), .IDX_W(IDX_W)) i_addr (
        .state    (st_q),
        .base     (base_q),
        .idx      (idx_q),
        .buf_base (buf_q),
        .cnt      (cnt_q),
        .addr     (mem_addr)
    );

    txr_byte_sel #(.DW(32)) i_bsel (
        .word   (word_q),
        .sel    (cnt_q[1:0]),
        .byte_o (tx_data)
    );

    txr_int_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ok  (set_ok),
        .set_err (set_err),
        .clr     (int_clr),
        .flags   (int_status)
    );
endmodule

// File: rtl/tx_ring_fetch_chk.sv
module tx_ring_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_first,
    input logic          tx_last,
    input logic [7:0]    int_status
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));

    assert_own_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    assert_ok_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[2]) |-> $past(mem_ack && mem_we));

    assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[3]) |-> $past(mem_ack && mem_we));

    assert_marks_in_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_first || tx_last) |-> tx_valid);

    assert_stream_or_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && mem_req));
endmodule

bind tx_ring_fetch tx_ring_fetch_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_tx_ring_fetch.sv
`timescale 1ns/1ps
module test_tx_ring_fetch;
    localparam int AW   = 32;
    localparam int RN   = 6;
    localparam int RING = 32'h100;
    localparam int BUFB = 32'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          base_wr = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          poll_wr = 1'b0;
    logic [7:0]    poll_data = '0;
    logic [7:0]    int_clr = '0;
    logic [7:0]    int_status;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          tx_valid, tx_first, tx_last;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;

    int checks = 0, errors = 0, exp_idx = 0;
    bit stall_en = 1'b0;

    logic [31:0] img [0:4095];
    int stat_log [0:1023]; int stat_n = 0;
    int wr_addr [0:1023];  logic [31:0] wr_data [0:1023]; int wr_n = 0;
    logic [7:0] cap_d [0:4095]; bit cap_f [0:4095]; bit cap_l [0:4095]; int cap_n = 0;

    tx_ring_fetch #(.AW(AW)) i_tx_ring_fetch (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
        .poll_wr(poll_wr), .poll_data(poll_data), .int_clr(int_clr),
        .int_status(int_status), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    // memory model with random latency; logs status reads and writes
    bit m_busy = 1'b0; int m_cnt = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy = 1'b0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    if (wr_n < 1024) begin wr_addr[wr_n] = int'(mem_addr); wr_data[wr_n] = mem_wdata; wr_n++; end
                end else begin
                    mem_rdata <= img[mem_addr[13:2]];
                    if (mem_addr >= RING && mem_addr < RING + 16*RN && mem_addr[3:0] == 4'h0 && stat_n < 1024) begin
                        stat_log[stat_n] = int'(mem_addr); stat_n++;
                    end
                end
            end else m_cnt--;
        end else if (rst_n && mem_req && !mem_ack) begin
            m_busy = 1'b1;
            m_cnt  = int'($urandom % 3);
        end
    end

    // sink: drive ready and record accepted bytes away from the rising edge
    always @(negedge clk) begin
        tx_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
        if (rst_n && tx_valid && tx_ready && cap_n < 4096) begin
            cap_d[cap_n] = tx_data; cap_f[cap_n] = tx_first; cap_l[cap_n] = tx_last; cap_n++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] img_byte(input int a);
        logic [31:0] w;
        w = img[a >> 2];
        return w[8*(a % 4) +: 8];
    endfunction

    task automatic ring(input logic [7:0] v);
        @(negedge clk); poll_wr = 1'b1; poll_data = v;
        @(negedge clk); poll_wr = 1'b0; poll_data = '0;
    endtask

    task automatic clear_ints(input logic [7:0] v);
        @(negedge clk); int_clr = v;
        @(negedge clk); int_clr = '0;
    endtask

    task automatic load_base(input int b);
        @(negedge clk); base_wr = 1'b1; base_addr = AW'(b);
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 30) begin
            @(negedge clk);
            if (mem_req || tx_valid) quiet = 0; else quiet++;
        end
    endtask

    task automatic put_desc(input int i, input logic [31:0] st, input int b);
        int w = (RING + 16*i) >> 2;
        img[w] = st; img[w+1] = $urandom; img[w+2] = b; img[w+3] = 32'h0;
    endtask

    // run n owned frames starting at exp_idx, followed by one unowned slot
    task automatic run_frames(input int n, input int zero_at, input bit mid_bell, input bit stall);
        logic [7:0] ed [0:511]; bit ef [0:511]; bit el [0:511];
        logic [31:0] est [0:7]; int eidx [0:7];
        int en = 0, s0, w0, c0, u, bad, nreads, ureads;
        bit any_ok = 0, any_err = 0, ok;
        logic [31:0] ust;
        stall_en = stall;
        for (int j = 0; j < n; j++) begin
            int i = (exp_idx + j) % RN;
            int len = (j == zero_at) ? 0 : (mid_bell ? 24 + int'($urandom % 16) : 1 + int'($urandom % 40));
            bit fs = $urandom % 2, ls = $urandom % 2;
            int b = BUFB + i*64;
            logic [31:0] st;
            st = 32'h8000_0000 | ((i == RN-1) ? 32'h4000_0000 : 0) | (fs ? 32'h2000_0000 : 0) |
                 (ls ? 32'h1000_0000 : 0) | ($urandom & 32'h0FFF_E000) | len;
            for (int w = 0; w < 16; w++) img[(b >> 2) + w] = $urandom;
            put_desc(i, st, b);
            est[j] = st & 32'h7FFF_FFFF; eidx[j] = i;
            if (len == 0) any_err = 1; else any_ok = 1;
            for (int k = 0; k < len; k++) begin
                ed[en] = img_byte(b + k); ef[en] = (k == 0) && fs; el[en] = (k == len-1) && ls; en++;
            end
        end
        u = (exp_idx + n) % RN;
        ust = ($urandom & 32'h3FFF_FFFF) | ((u == RN-1) ? 32'h4000_0000 : 0);
        put_desc(u, ust, BUFB + u*64);
        clear_ints(8'hFF);
        s0 = stat_n; w0 = wr_n; c0 = cap_n;
        ring(8'h40 | 8'($urandom & 8'hBF));
        if (mid_bell) begin
            wait (tx_valid);
            ring(8'h40);
        end
        wait_idle();
        // R2 / R3: walk starts at the current slot
        check(stat_log[s0] == RING + 16*exp_idx, "R2 start slot", stat_log[s0], RING + 16*exp_idx);
        // R4: byte count and content
        check(cap_n - c0 == en, "R4 byte count", cap_n - c0, en);
        bad = -1;
        for (int k = 0; k < en && k < cap_n - c0; k++) if (cap_d[c0+k] != ed[k] && bad < 0) bad = k;
        check(bad < 0, "R4 byte data", (bad < 0) ? 0 : cap_d[c0+bad], (bad < 0) ? 0 : ed[bad]);
        // R5: frame marks
        bad = -1;
        for (int k = 0; k < en && k < cap_n - c0; k++)
            if ((cap_f[c0+k] != ef[k] || cap_l[c0+k] != el[k]) && bad < 0) bad = k;
        check(bad < 0, "R5 first/last marks", bad, -1);
        // R6: write-backs
        check(wr_n - w0 == n, "R6 write count", wr_n - w0, n);
        ok = 1; bad = 0;
        for (int j = 0; j < n && j < wr_n - w0; j++)
            if (wr_addr[w0+j] != RING + 16*eidx[j] || wr_data[w0+j] != est[j]) begin ok = 0; bad = j; end
        check(ok, "R6 status write-back", wr_data[w0+bad], est[bad]);
        // R7: slot order including wrap on the end-of-ring flag
        nreads = stat_n - s0; ok = (nreads >= n + 1);
        for (int j = 0; j < n && ok; j++) if (stat_log[s0+j] != RING + 16*eidx[j]) ok = 0;
        check(ok, "R7 walk order", nreads, n + 1);
        // R3 / R10: unowned slot read once, twice with a held doorbell; never written
        ureads = 0;
        for (int j = s0; j < stat_n; j++) if (stat_log[j] == RING + 16*u) ureads++;
        check(ureads == (mid_bell ? 2 : 1), "R10 unowned rescans", ureads, mid_bell ? 2 : 1);
        ok = 1;
        for (int j = w0; j < wr_n; j++) if (wr_addr[j] == RING + 16*u) ok = 0;
        check(ok, "R3 unowned untouched", 0, 0);
        check(int_status[2] == any_ok, "R9 done flag", int_status[2], any_ok);
        check(int_status[3] == any_err, "R8 error flag", int_status[3], any_err);
        exp_idx = u;
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, w0, c0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) img[i] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(mem_req == 1'b0, "R1 no request", mem_req, 0);
        check(tx_valid == 1'b0, "R1 no byte", tx_valid, 0);
        check(int_status == 8'h00, "R1 flags clear", int_status, 0);
        load_base(RING);
        exp_idx = 0;

        // R2: doorbell bit clear starts nothing
        s0 = stat_n;
        ring(8'hBF);
        wait_idle();
        check(stat_n == s0, "R2 bit6 clear ignored", stat_n - s0, 0);

        // first walk from slot 0 (R1 index zero)
        run_frames(2, -1, 1'b0, 1'b0);

        // R9: flags clear selectively
        clear_ints(8'h08);
        check(int_status[2] == 1'b1, "R9 done flag kept", int_status[2], 1);
        clear_ints(8'h04);
        check(int_status[2] == 1'b0, "R9 done flag cleared", int_status[2], 0);

        // R3: unowned slot stops the walk with no write and no bytes
        put_desc(exp_idx, 32'h0000_0010, BUFB);
        s0 = stat_n; w0 = wr_n; c0 = cap_n;
        ring(8'h40);
        wait_idle();
        check(stat_n - s0 == 1 && stat_log[s0] == RING + 16*exp_idx, "R3 single status read", stat_n - s0, 1);
        check(wr_n == w0 && cap_n == c0, "R3 no write, no bytes", wr_n - w0 + cap_n - c0, 0);
        check(int_status == 8'h00, "R3 flags unchanged", int_status, 0);

        // R8: zero-length descriptor in the middle
        run_frames(3, 1, 1'b0, 1'b1);
        // R7: walk crossing the end-of-ring slot
        run_frames(4, -1, 1'b0, 1'b1);
        // R10: doorbell while streaming
        run_frames(1, -1, 1'b1, 1'b1);
        // R12: base reload returns to slot 0
        load_base(RING);
        exp_idx = 0;
        run_frames(2, -1, 1'b0, 1'b0);

        for (int r = 0; r < 10; r++) begin
            int n = 1 + int'($urandom % (RN - 1));
            int z = (($urandom % 4) == 0) ? int'($urandom % n) : -1;
            run_frames(n, z, 1'b0, bit'($urandom % 2));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule